// File: doc/BRIEF.md
# Segmented Vector Memory Address Sequencer

This block turns one segmented vector load or store command into the ordered series of memory requests that carries it out. A command gives a base address, an element stride or a request for unit stride, the byte size of one field, the vector length and the 32-bit instruction word. The segment count (fields per element) and the first register index are taken from fixed fields of that word. The command also says which register file the transfer uses (integer or float) and the number of registers currently configured in each file.

The sequencer walks every element. Within each element it walks every field, and each field goes into the next register after the previous one. For each step it presents an address, a register index and an element index under a valid/ready handshake. A register index outside the configured file size stops the walk with an error. A command given without supervisor status is refused with a different error. The memory, the register files and the data path are not part of this block.

Top module: `segvec_addr_seq`

## Requirements
- R1: The segment count is cmd_insn[31:29] plus one (1 to 8), and the first register index is cmd_insn[11:7]; a legal command issues vector length times segment count requests.
- R2: Requests run field-innermost: element 0 fields 0..S-1, then element 1, and so on; req_elem carries the element index of each request.
- R3: With cmd_strided=1, element i starts at cmd_base + i*cmd_stride. Field j of that element is at the element start + j*cmd_esize, modulo 2^AW.
- R4: With cmd_strided=0, cmd_stride is ignored and the element stride is the segment count times cmd_esize.
- R5: Field j of every element has req_reg = first register + j. req_store and req_fp repeat cmd_store and cmd_fp.
- R6: When the next register index is at or above the limit of the selected file, that request is not presented. The limit is cfg_nfpr when cmd_fp=1 and cfg_nxpr otherwise, and counts above 32 act as 32. One cycle later err=1 with err_cause=1 and err_insn holding the command word. busy falls and req_valid stays low. Requests before that one are issued normally.
- R7: A start with priv_ok=0 issues no request and no done. One cycle later err=1 with err_cause=2 and err_insn holding the command word.
- R8: While req_valid=1 and req_ready=0, the next cycle still has req_valid=1 with req_addr, req_reg and req_elem unchanged.
- R9: A permitted start with cmd_vl=0 issues no request, performs no register check, and pulses done in the next cycle.
- R10: done is high for exactly one cycle, the cycle after the last request is accepted, and busy is low from then on.
- R11: start is ignored while busy=1; the running sequence continues unchanged.
- R12: After reset req_valid, busy, done and err are all low. err stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_base | input | AW | First element address |
| cmd_strided | input | 1 | 1: use cmd_stride; 0: unit stride |
| cmd_stride | input | AW | Element stride in bytes |
| cmd_esize | input | EW | Field byte size |
| cmd_vl | input | LW | Vector length |
| cmd_insn | input | 32 | Instruction word (segment count, first register) |
| cmd_fp | input | 1 | 1: float file, 0: integer file |
| cmd_store | input | 1 | 1: store (registers read), 0: load |
| cfg_nxpr | input | 6 | Configured integer register count |
| cfg_nfpr | input | 6 | Configured float register count |
| priv_ok | input | 1 | Supervisor status |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | AW | Field byte address |
| req_reg | output | 5 | Target register index |
| req_elem | output | LW | Element index |
| req_store | output | 1 | Direction of the request |
| req_fp | output | 1 | Register file of the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Exception raised |
| err_cause | output | 2 | 1 illegal register, 2 privilege |
| err_insn | output | 32 | Command word that faulted |

## Verification
Random commands cover segment counts 1 to 8, field sizes 1 to 8 bytes, short vector lengths, both strides and random ready gaps. This shows whether the address nest, the element index and the register step are right, and whether each one holds under backpressure. Commands whose limits cut into the first element tell apart a check made per request from a check made once per command. Directed cases use vector length zero, refused privilege, a first register already out of range, and a start pulse in the middle of a run. These separate the refusal paths and show that the running sequence ignores a new command.

// File: rtl/segvec_addr_seq.sv
module segvec_addr_seq #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_base,
  input  logic          cmd_strided,
  input  logic [AW-1:0] cmd_stride,
  input  logic [EW-1:0] cmd_esize,
  input  logic [LW-1:0] cmd_vl,
  input  logic [31:0]   cmd_insn,
  input  logic          cmd_fp,
  input  logic          cmd_store,
  input  logic [5:0]    cfg_nxpr,
  input  logic [5:0]    cfg_nfpr,
  input  logic          priv_ok,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [4:0]    req_reg,
  output logic [LW-1:0] req_elem,
  output logic          req_store,
  output logic          req_fp,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_cause,
  output logic [31:0]   err_insn
);
  localparam int SGW = 3;
  localparam int RIW = 5;
  localparam logic [1:0] CAUSE_REG  = 2'd1;
  localparam logic [1:0] CAUSE_PRIV = 2'd2;

  logic [AW-1:0]  eaddr_q, faddr_q, stride_q;
  logic [EW-1:0]  esize_q;
  logic [LW-1:0]  vl_q, elem_q;
  logic [SGW:0]   seg_q;
  logic [SGW-1:0] fld_q;
  logic [RIW:0]   reg_q, rd_q, lim_q;
  logic           busy_q, done_q, err_q, store_q, fp_q;
  logic [1:0]     cause_q;
  logic [31:0]    insn_q;

  wire [SGW:0]  seg_in  = {1'b0, cmd_insn[31:29]} + 1'b1;
  wire [RIW:0]  rd_in   = {1'b0, cmd_insn[11:7]};
  wire [AW-1:0] unit_st = AW'(seg_in) * AW'(cmd_esize);
  wire [AW-1:0] stride_in = cmd_strided ? cmd_stride : unit_st;
  wire [RIW:0]  lim_in  = cmd_fp ? cfg_nfpr : cfg_nxpr;
  wire [AW-1:0] next_elem_addr = eaddr_q + stride_q;

  wire illegal   = busy_q && (reg_q >= lim_q || reg_q[RIW]);
  wire fire      = busy_q && !illegal && req_ready;
  wire last_fld  = ({1'b0, fld_q} + 1'b1) == seg_q;
  wire last_elem = ({1'b0, elem_q} + 1'b1) == {1'b0, vl_q};
  wire take      = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cause_q  <= 2'd0;
      insn_q   <= '0;
      eaddr_q  <= '0;
      faddr_q  <= '0;
      stride_q <= '0;
      esize_q  <= '0;
      vl_q     <= '0;
      elem_q   <= '0;
      seg_q    <= '0;
      fld_q    <= '0;
      reg_q    <= '0;
      rd_q     <= '0;
      lim_q    <= '0;
      store_q  <= 1'b0;
      fp_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        err_q    <= 1'b0;
        cause_q  <= 2'd0;
        insn_q   <= cmd_insn;
        eaddr_q  <= cmd_base;
        faddr_q  <= cmd_base;
        stride_q <= stride_in;
        esize_q  <= cmd_esize;
        vl_q     <= cmd_vl;
        elem_q   <= '0;
        seg_q    <= seg_in;
        fld_q    <= '0;
        reg_q    <= rd_in;
        rd_q     <= rd_in;
        lim_q    <= lim_in;
        store_q  <= cmd_store;
        fp_q     <= cmd_fp;
        if (!priv_ok) begin
          err_q   <= 1'b1;
          cause_q <= CAUSE_PRIV;
        end else if (cmd_vl == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (illegal) begin
        busy_q  <= 1'b0;
        err_q   <= 1'b1;
        cause_q <= CAUSE_REG;
      end else if (fire) begin
        if (last_fld) begin
          fld_q <= '0;
          reg_q <= rd_q;
          if (last_elem) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            elem_q  <= elem_q + 1'b1;
            eaddr_q <= next_elem_addr;
            faddr_q <= next_elem_addr;
          end
        end else begin
          fld_q   <= fld_q + 1'b1;
          faddr_q <= faddr_q + AW'(esize_q);
          reg_q   <= reg_q + 1'b1;
        end
      end
    end
  end

  assign req_valid = busy_q && !illegal;
  assign req_addr  = faddr_q;
  assign req_reg   = reg_q[RIW-1:0];
  assign req_elem  = elem_q;
  assign req_store = store_q;
  assign req_fp    = fp_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_cause = cause_q;
  assign err_insn  = insn_q;
endmodule

// File: rtl/segvec_addr_seq_chk.sv
module segvec_addr_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int EW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] cmd_vl,
  input logic [31:0]   cmd_insn,
  input logic          priv_ok,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    req_reg,
  input logic [LW-1:0] req_elem,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [1:0]    err_cause,
  input logic [31:0]   err_insn
);
  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |=> (!req_valid && !busy && !done && !err));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_reg) && $stable(req_elem)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid);

  assert_priv_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !priv_ok) |=> (err && err_cause == 2'd2 && !busy &&
                                      err_insn == $past(cmd_insn)));

  assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && priv_ok && cmd_vl == '0) |=> (done && !req_valid));

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && req_valid && !req_ready) |=> (busy && $stable(req_addr)));
endmodule

bind segvec_addr_seq segvec_addr_seq_chk #(.AW(AW), .LW(LW), .EW(EW)) chk_i (.*);

// File: tb/segvec_addr_seq_tb_top.sv
module segvec_addr_seq_tb_top;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int EW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cmd_base = '0;
  logic          cmd_strided = 1'b0;
  logic [AW-1:0] cmd_stride = '0;
  logic [EW-1:0] cmd_esize = '0;
  logic [LW-1:0] cmd_vl = '0;
  logic [31:0]   cmd_insn = '0;
  logic          cmd_fp = 1'b0;
  logic          cmd_store = 1'b0;
  logic [5:0]    cfg_nxpr = 6'd32;
  logic [5:0]    cfg_nfpr = 6'd32;
  logic          priv_ok = 1'b1;
  logic          req_ready = 1'b0;
  logic          req_valid, req_store, req_fp, busy, done, err;
  logic [AW-1:0] req_addr;
  logic [4:0]    req_reg;
  logic [LW-1:0] req_elem;
  logic [1:0]    err_cause;
  logic [31:0]   err_insn;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segvec_addr_seq #(.AW(AW), .LW(LW), .EW(EW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic [AW-1:0] st,
                                            int esz, int i, int j);
    return base + AW'(i) * st + AW'(j * esz);
  endfunction

  function automatic int exp_count(int vl, int seg, int rd, int lim, output bit ill);
    int l = (lim > 32) ? 32 : lim;
    ill = 1'b0;
    if (vl == 0) return 0;
    if (rd + seg - 1 >= l) begin
      ill = 1'b1;
      return (rd >= l) ? 0 : l - rd;
    end
    return vl * seg;
  endfunction

  task automatic run_cmd(input logic [AW-1:0] base, input bit strided, input logic [AW-1:0] st,
                         input int esz, input int vl, input int segf, input int rd,
                         input bit fp, input int nx, input int nf, input bit priv,
                         input bit store, input bit inject);
    logic [31:0] insn;
    logic [AW-1:0] est;
    int seg, nexp, k;
    bit ill, stalled;
    logic [AW-1:0] s_addr;
    logic [4:0] s_reg;
    logic [LW-1:0] s_elem;
    seg = segf + 1;
    insn = $urandom;
    insn[31:29] = 3'(segf);
    insn[11:7] = 5'(rd);
    est = strided ? st : AW'(seg * esz);
    nexp = exp_count(vl, seg, rd, fp ? nf : nx, ill);
    @(negedge clk);
    cmd_base = base; cmd_strided = strided; cmd_stride = st; cmd_esize = EW'(esz);
    cmd_vl = LW'(vl); cmd_insn = insn; cmd_fp = fp; cmd_store = store;
    cfg_nxpr = 6'(nx); cfg_nfpr = 6'(nf); priv_ok = priv; req_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (!priv) begin
      chk(err && err_cause == 2'd2, "R7 privilege cause", {err, err_cause}, 3'b110);
      chk(err_insn == insn, "R7 err_insn", err_insn, insn);
      chk(!req_valid && !done && !busy, "R7 nothing issued", {req_valid, done, busy}, 0);
      @(negedge clk); #1;
      chk(!req_valid && !done, "R7 still quiet", {req_valid, done}, 0);
      return;
    end
    if (vl == 0) begin
      chk(done && !busy && !req_valid, "R9 empty done", {done, busy, req_valid}, 3'b100);
      @(negedge clk); #1;
      chk(!done && !req_valid && !err, "R9 quiet after", {done, req_valid, err}, 0);
      return;
    end
    k = 0;
    stalled = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      req_ready = ($urandom % 4) != 0;
      if (inject && cyc == 2) begin
        start = 1'b1;
        cmd_base = ~base;
        cmd_vl = LW'(0);
        priv_ok = 1'b0;
      end
      #1;
      if (err) break;
      if (req_valid) begin
        if (stalled)
          chk(req_addr == s_addr && req_reg == s_reg && req_elem == s_elem,
              "R8 stall hold", req_addr, s_addr);
        chk(k < nexp, "R1 request count", k, nexp);
        chk(req_addr == exp_addr(base, est, esz, k / seg, k % seg),
            strided ? "R3 strided addr" : "R4 unit addr",
            req_addr, exp_addr(base, est, esz, k / seg, k % seg));
        chk(req_elem == LW'(k / seg), "R2 element order", req_elem, k / seg);
        chk(req_reg == 5'(rd + k % seg), "R5 register index", req_reg, rd + k % seg);
        chk(req_store == store && req_fp == fp, "R5 direction/file",
            {req_store, req_fp}, {store, fp});
        if (req_ready) begin
          k++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          s_addr = req_addr; s_reg = req_reg; s_elem = req_elem;
        end
      end
      @(negedge clk);
      start = 1'b0;
      priv_ok = 1'b1;
      if (!ill && k == nexp) break;
    end
    req_ready = 1'b0;
    #1;
    if (ill) begin
      chk(err && err_cause == 2'd1, "R6 register cause", {err, err_cause}, 3'b101);
      chk(err_insn == insn, "R6 err_insn", err_insn, insn);
      chk(k == nexp, "R6 issued before stop", k, nexp);
      for (int q = 0; q < 3; q++) begin
        @(negedge clk); #1;
        chk(!req_valid && !busy && !done, "R6 stays stopped", {req_valid, busy, done}, 0);
      end
    end else begin
      chk(done && !busy && !err, "R10 done after last", {done, busy, err}, 3'b100);
      chk(k == vl * seg, "R1 total requests", k, vl * seg);
      if (inject) chk(!err, "R11 start ignored while busy", err, 0);
      @(negedge clk); #1;
      chk(!done && !req_valid, "R10 done one cycle", {done, req_valid}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid && !busy && !done && !err, "R12 reset state",
        {req_valid, busy, done, err}, 0);
    rst_n = 1'b1;
    run_cmd(32'h1000, 1'b0, 32'hDEAD, 4, 3, 2, 4, 1'b0, 32, 32, 1'b1, 1'b0, 1'b0);
    run_cmd(32'h2000, 1'b1, 32'h40, 8, 4, 1, 10, 1'b1, 32, 32, 1'b1, 1'b1, 1'b0);
    run_cmd(32'hFFFF_FFF0, 1'b1, 32'h10, 2, 3, 7, 0, 1'b0, 32, 32, 1'b1, 1'b0, 1'b0);
    run_cmd(32'h3000, 1'b0, 32'h0, 1, 0, 3, 5, 1'b0, 1, 1, 1'b1, 1'b0, 1'b0);
    run_cmd(32'h4000, 1'b0, 32'h0, 4, 2, 1, 5, 1'b0, 32, 32, 1'b0, 1'b0, 1'b0);
    run_cmd(32'h5000, 1'b0, 32'h0, 4, 2, 3, 6, 1'b1, 32, 8, 1'b1, 1'b0, 1'b0);
    run_cmd(32'h6000, 1'b0, 32'h0, 4, 2, 0, 20, 1'b0, 20, 32, 1'b1, 1'b1, 1'b0);
    run_cmd(32'h7000, 1'b1, 32'h100, 4, 5, 2, 28, 1'b0, 40, 32, 1'b1, 1'b0, 1'b0);
    run_cmd(32'h8000, 1'b1, 32'h20, 4, 4, 1, 3, 1'b0, 32, 32, 1'b1, 1'b0, 1'b1);
    for (int n = 0; n < 60; n++) begin
      int segf, rd, esz, nx, nf;
      segf = $urandom % 8;
      rd = $urandom % 32;
      esz = 1 << ($urandom % 4);
      nx = ($urandom % 2) ? 32 : 1 + $urandom % 32;
      nf = ($urandom % 2) ? 32 : 1 + $urandom % 32;
      run_cmd($urandom, $urandom % 2, $urandom % 512, esz, $urandom % 6, segf, rd,
              $urandom % 2, nx, nf, ($urandom % 10) != 0, $urandom % 2, ($urandom % 8) == 0);
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule